// File: doc/BRIEF.md
# Ethernet Pause Flow Controller

This block handles MAC-control pause flow control in both directions of a full-duplex Ethernet port. On the transmit side it watches a congestion input from the local receive buffer. When congestion appears it emits a pause frame that asks the link partner to stop sending for a fixed number of quanta (XOFF). If the congestion clears while that request is still in force, it emits a second pause frame with a zero parameter (XON) so the partner resumes at once. If the congestion lasts until the request runs out, the XOFF is sent again. Generated frames are 60 bytes, padded with zeros, and go to the FCS stage that follows the block.

On the receive side the block parses the incoming byte stream on the fly. It recognises pause frames by their reserved multicast destination, their MAC-control type and their pause opcode. It then drives a hold output that keeps the local transmitter silent for the requested number of quanta. The quanta are counted on an external tick that marks every 512 bit times. A new XOFF reloads the hold timer and an XON ends the hold at once. Pause generation and pause reaction each have their own enable, so flow control can run in one direction only.

Top module: `pause_flow_ctrl`

## Requirements
- R1: When `congested` rises while `txPauseEn` is high and no frame is being sent, the block emits a 60-byte frame on consecutive cycles, starting one cycle after the clock edge that samples `congested`. The bytes are: 0-5 = 01 80 C2 00 00 01, 6-11 = `stationAddr` with the most significant byte first, 12-13 = 88 08, 14-15 = 00 01, 16-17 = the parameter `XOFF_QUANTA` (default 64) with the high byte first, and 18-59 = 00. `txOutSof` is high on byte 0 and `txOutEof` is high on byte 59.
- R2: Each XOFF opens a window of `XOFF_QUANTA` quanta ticks. If `congested` falls while the window is still open, the block emits the same frame with parameter 0 (XON).
- R3: If congestion persists until the window closes, the block sends the XOFF again. If congestion falls after the window has closed, no XON is sent.
- R4: While `txPauseEn` is low, no frame starts. A frame that is pending starts after the enable returns.
- R5: A received frame is accepted as a pause frame when all of these hold: `rxSof` marks its byte 0, bytes 0-5 equal 01 80 C2 00 00 01, bytes 12-13 equal 88 08, bytes 14-15 equal 00 01, and `rxEof` falls on byte 17 or later. If such a frame carries a nonzero parameter (bytes 16-17, high byte first), `txHold` rises two clock edges after the edge that samples the end byte.
- R6: The hold timer counts down by one on each `quantaTick`. `txHold` stays high until the tick that brings the count to zero.
- R7: An accepted nonzero pause frame reloads the timer even while it is already running.
- R8: An accepted pause frame with parameter 0 clears the timer and ends the hold.
- R9: A frame with a wrong destination, type or opcode, or one that ends before byte 17, leaves the hold state unchanged.
- R10: While `rxPauseEn` is low, `txHold` is forced low and received pause frames have no effect.
- R11: After reset, `txOutValid` and `txHold` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stationAddr | input | 48 | Local station address, used as the source of generated frames |
| txPauseEn | input | 1 | Allows pause frames to be generated |
| rxPauseEn | input | 1 | Allows the block to react to received pause frames |
| congested | input | 1 | Receive congestion level |
| quantaTick | input | 1 | One-cycle pulse every pause quantum (512 bit times) |
| rxValid | input | 1 | Received byte valid |
| rxSof | input | 1 | First byte of a received frame |
| rxEof | input | 1 | Last byte of a received frame |
| rxData | input | 8 | Received byte |
| txOutValid | output | 1 | Generated frame byte valid |
| txOutSof | output | 1 | First byte of a generated frame |
| txOutEof | output | 1 | Last byte of a generated frame |
| txOutData | output | 8 | Generated frame byte |
| txHold | output | 1 | Holds off the local transmitter |

## Verification
A generated frame's first byte appears one cycle after the edge that samples a change on `congested`, and each later byte follows one cycle after the one before it. The bench changes inputs on falling edges and reads each byte at the next falling edge. The bench waits for the start marker with a bounded search, then compares all 60 bytes in lockstep against a frame it builds itself. For the receive direction, `txHold` changes two edges after the end byte is sampled, and one edge after a tick or a change of `rxPauseEn`. The bench therefore reads the hold one falling edge after it drops `rxValid`, or one falling edge after each tick pulse. It tracks the remaining quanta in its own model while random good and damaged frames and random tick counts are mixed in.

// File: rtl/pause_fc_pkg.sv
package pause_fc_pkg;
  localparam logic [47:0] PAUSE_DEST    = 48'h0180C2000001;
  localparam logic [15:0] MAC_CTRL_TYPE = 16'h8808;
  localparam logic [15:0] PAUSE_OPCODE  = 16'h0001;
  localparam int QUANTA_W     = 16;
  localparam int PARSE_IDX_W  = 5;
  localparam int PARAM_HI_POS = 16;
  localparam int PARAM_LO_POS = 17;

  typedef struct packed {
    logic txStart;
    logic txXoff;
    logic holdLoad;
    logic holdClear;
  } ctrlStrobes_t;

  typedef struct packed {
    logic                txBusy;
    logic                rxEvent;
    logic [QUANTA_W-1:0] rxParam;
  } dpStatus_t;
endpackage

// File: rtl/pause_fc_datapath.sv
module pause_fc_datapath
  import pause_fc_pkg::*;
#(
  parameter int                  FRAME_BYTES = 60,
  parameter logic [QUANTA_W-1:0] XOFF_QUANTA = 16'd64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [47:0]         stationAddr,
  input  logic                rxValid,
  input  logic                rxSof,
  input  logic                rxEof,
  input  logic [7:0]          rxData,
  input  logic                quantaTick,
  input  ctrlStrobes_t        strobes,
  output dpStatus_t           status,
  output logic                txOutValid,
  output logic                txOutSof,
  output logic                txOutEof,
  output logic [7:0]          txOutData,
  output logic [QUANTA_W-1:0] holdCount
);
  localparam int IDX_W = $clog2(FRAME_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);
  localparam logic [PARSE_IDX_W-1:0] PARSE_SAT = '1;

  // ---------------- frame generator ----------------
  logic                txBusy;
  logic [IDX_W-1:0]    txIdx;
  logic [QUANTA_W-1:0] txParam;
  int                  txPos;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBusy  <= 1'b0;
      txIdx   <= '0;
      txParam <= '0;
    end else if (strobes.txStart && !txBusy) begin
      txBusy  <= 1'b1;
      txIdx   <= '0;
      txParam <= strobes.txXoff ? XOFF_QUANTA : '0;
    end else if (txBusy) begin
      txIdx  <= txIdx + 1'b1;
      txBusy <= (txIdx != LAST_IDX);
    end
  end

  assign txPos = int'(txIdx);

  always_comb begin
    if (txPos < 6)
      txOutData = 8'(PAUSE_DEST >> (8 * (5 - txPos)));
    else if (txPos < 12)
      txOutData = 8'(stationAddr >> (8 * (11 - txPos)));
    else begin
      case (txPos)
        12:           txOutData = MAC_CTRL_TYPE[15:8];
        13:           txOutData = MAC_CTRL_TYPE[7:0];
        14:           txOutData = PAUSE_OPCODE[15:8];
        15:           txOutData = PAUSE_OPCODE[7:0];
        PARAM_HI_POS: txOutData = txParam[15:8];
        PARAM_LO_POS: txOutData = txParam[7:0];
        default:      txOutData = 8'h00;
      endcase
    end
  end

  assign txOutValid = txBusy;
  assign txOutSof   = txBusy && (txIdx == '0);
  assign txOutEof   = txBusy && (txIdx == LAST_IDX);

  // ---------------- receive parser ----------------
  logic [PARSE_IDX_W-1:0] rxIdx, rxPos;
  logic                   rxMatch, byteOk, matchNext, rxEvent;
  logic [7:0]             rxHi, rxLo;
  logic [QUANTA_W-1:0]    rxParam;

  assign rxPos = rxSof ? '0 : rxIdx;

  always_comb begin
    case (rxPos)
      5'd0:    byteOk = (rxData == PAUSE_DEST[47:40]);
      5'd1:    byteOk = (rxData == PAUSE_DEST[39:32]);
      5'd2:    byteOk = (rxData == PAUSE_DEST[31:24]);
      5'd3:    byteOk = (rxData == PAUSE_DEST[23:16]);
      5'd4:    byteOk = (rxData == PAUSE_DEST[15:8]);
      5'd5:    byteOk = (rxData == PAUSE_DEST[7:0]);
      5'd12:   byteOk = (rxData == MAC_CTRL_TYPE[15:8]);
      5'd13:   byteOk = (rxData == MAC_CTRL_TYPE[7:0]);
      5'd14:   byteOk = (rxData == PAUSE_OPCODE[15:8]);
      5'd15:   byteOk = (rxData == PAUSE_OPCODE[7:0]);
      default: byteOk = 1'b1;
    endcase
  end

  assign matchNext = byteOk && (rxSof || rxMatch);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxIdx   <= PARSE_SAT;
      rxMatch <= 1'b0;
      rxHi    <= '0;
      rxLo    <= '0;
      rxEvent <= 1'b0;
      rxParam <= '0;
    end else begin
      rxEvent <= 1'b0;
      if (rxValid) begin
        rxMatch <= rxEof ? 1'b0 : matchNext;
        if (rxEof || rxPos == PARSE_SAT) rxIdx <= PARSE_SAT;
        else                             rxIdx <= rxPos + 1'b1;
        if (rxPos == PARSE_IDX_W'(PARAM_HI_POS)) rxHi <= rxData;
        if (rxPos == PARSE_IDX_W'(PARAM_LO_POS)) rxLo <= rxData;
        if (rxEof && matchNext && rxPos >= PARSE_IDX_W'(PARAM_LO_POS)) begin
          rxEvent <= 1'b1;
          rxParam <= (rxPos == PARSE_IDX_W'(PARAM_LO_POS)) ? {rxHi, rxData} : {rxHi, rxLo};
        end
      end
    end
  end

  // ---------------- hold timer ----------------
  always_ff @(posedge clk) begin
    if (!rstN)                               holdCount <= '0;
    else if (strobes.holdClear)              holdCount <= '0;
    else if (strobes.holdLoad)               holdCount <= rxParam;
    else if (quantaTick && holdCount != '0)  holdCount <= holdCount - 1'b1;
  end

  assign status.txBusy  = txBusy;
  assign status.rxEvent = rxEvent;
  assign status.rxParam = rxParam;
endmodule

// File: rtl/pause_fc_ctrl.sv
module pause_fc_ctrl
  import pause_fc_pkg::*;
#(
  parameter logic [QUANTA_W-1:0] XOFF_QUANTA = 16'd64
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         congested,
  input  logic         txPauseEn,
  input  logic         rxPauseEn,
  input  logic         quantaTick,
  input  dpStatus_t    status,
  output ctrlStrobes_t strobes
);
  logic                xoffSent;
  logic [QUANTA_W-1:0] windowCnt;
  logic                windowOpen, wantXoff, wantXon, expireDrop, startNow;

  assign windowOpen = (windowCnt != '0);
  assign wantXoff   = congested && (!xoffSent || !windowOpen);
  assign wantXon    = !congested && xoffSent && windowOpen;
  assign expireDrop = !congested && xoffSent && !windowOpen;
  assign startNow   = txPauseEn && !status.txBusy && (wantXoff || wantXon);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xoffSent  <= 1'b0;
      windowCnt <= '0;
    end else if (startNow && wantXoff) begin
      xoffSent  <= 1'b1;
      windowCnt <= XOFF_QUANTA;
    end else if (startNow || expireDrop) begin
      xoffSent  <= 1'b0;
      windowCnt <= '0;
    end else if (quantaTick && windowOpen) begin
      windowCnt <= windowCnt - 1'b1;
    end
  end

  always_comb begin
    strobes.txStart   = startNow;
    strobes.txXoff    = wantXoff;
    strobes.holdLoad  = rxPauseEn && status.rxEvent && (status.rxParam != '0);
    strobes.holdClear = !rxPauseEn || (status.rxEvent && status.rxParam == '0);
  end
endmodule

// File: rtl/pause_flow_ctrl.sv
module pause_flow_ctrl
  import pause_fc_pkg::*;
#(
  parameter int                  FRAME_BYTES = 60,
  parameter logic [QUANTA_W-1:0] XOFF_QUANTA = 16'd64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [47:0] stationAddr,
  input  logic        txPauseEn,
  input  logic        rxPauseEn,
  input  logic        congested,
  input  logic        quantaTick,
  input  logic        rxValid,
  input  logic        rxSof,
  input  logic        rxEof,
  input  logic [7:0]  rxData,
  output logic        txOutValid,
  output logic        txOutSof,
  output logic        txOutEof,
  output logic [7:0]  txOutData,
  output logic        txHold
);
  ctrlStrobes_t        strobes;
  dpStatus_t           dpStat;
  logic [QUANTA_W-1:0] holdCount;

  pause_fc_ctrl #(.XOFF_QUANTA(XOFF_QUANTA)) u_ctrl (
    .clk(clk), .rstN(rstN), .congested(congested), .txPauseEn(txPauseEn),
    .rxPauseEn(rxPauseEn), .quantaTick(quantaTick), .status(dpStat), .strobes(strobes)
  );

  pause_fc_datapath #(.FRAME_BYTES(FRAME_BYTES), .XOFF_QUANTA(XOFF_QUANTA)) u_dp (
    .clk(clk), .rstN(rstN), .stationAddr(stationAddr), .rxValid(rxValid),
    .rxSof(rxSof), .rxEof(rxEof), .rxData(rxData), .quantaTick(quantaTick),
    .strobes(strobes), .status(dpStat), .txOutValid(txOutValid), .txOutSof(txOutSof),
    .txOutEof(txOutEof), .txOutData(txOutData), .holdCount(holdCount)
  );

  assign txHold = (holdCount != '0);
endmodule

// File: rtl/pause_fc_checker.sv
module pause_fc_checker
  import pause_fc_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                txPauseEn,
  input logic                rxPauseEn,
  input logic                txOutValid,
  input logic                txOutSof,
  input logic                txOutEof,
  input logic [7:0]          txOutData,
  input logic                txHold,
  input ctrlStrobes_t        strobes,
  input dpStatus_t           dpStat,
  input logic [QUANTA_W-1:0] holdCount
);
  a_r1_sof_is_dest_byte: assert property (@(posedge clk) disable iff (!rstN)
    (txOutValid && txOutSof) |-> (txOutData == PAUSE_DEST[47:40]));

  a_r1_gap_after_eof: assert property (@(posedge clk) disable iff (!rstN)
    (txOutValid && txOutEof) |=> !txOutValid);

  a_r4_no_start_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (!txPauseEn && !txOutValid) |=> !txOutValid);

  a_r6_hold_never_grows: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.holdLoad |=> (holdCount <= $past(holdCount)));

  a_r8_xon_ends_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rxPauseEn && dpStat.rxEvent && dpStat.rxParam == '0) |=> !txHold);

  a_r10_hold_off_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !rxPauseEn |=> !txHold);
endmodule

bind pause_flow_ctrl pause_fc_checker u_chk (
  .clk(clk), .rstN(rstN), .txPauseEn(txPauseEn), .rxPauseEn(rxPauseEn),
  .txOutValid(txOutValid), .txOutSof(txOutSof), .txOutEof(txOutEof),
  .txOutData(txOutData), .txHold(txHold), .strobes(strobes), .dpStat(dpStat),
  .holdCount(holdCount)
);

// File: tb/pause_flow_ctrl_bench.sv
`timescale 1ns/1ps
module pause_flow_ctrl_bench;
  localparam logic [47:0] DEST_OK = 48'h0180C2000001;
  localparam logic [15:0] XOFF_Q  = 16'd64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [47:0] stationAddr = 48'h021122334455;
  logic txPauseEn = 1'b0, rxPauseEn = 1'b0, congested = 1'b0, quantaTick = 1'b0;
  logic rxValid = 1'b0, rxSof = 1'b0, rxEof = 1'b0;
  logic [7:0] rxData = 8'h00;
  logic txOutValid, txOutSof, txOutEof, txHold;
  logic [7:0] txOutData;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int holdModel = 0;

  always #2.5 clk = ~clk;

  pause_flow_ctrl u_pause_flow_ctrl (
    .clk(clk), .rstN(rstN), .stationAddr(stationAddr), .txPauseEn(txPauseEn),
    .rxPauseEn(rxPauseEn), .congested(congested), .quantaTick(quantaTick),
    .rxValid(rxValid), .rxSof(rxSof), .rxEof(rxEof), .rxData(rxData),
    .txOutValid(txOutValid), .txOutSof(txOutSof), .txOutEof(txOutEof),
    .txOutData(txOutData), .txHold(txHold)
  );

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      finishRun();
    end
  end

  function automatic logic [7:0] txExp(int i, logic [15:0] prm, logic [47:0] sa);
    if (i < 6)       return 8'(DEST_OK >> (8 * (5 - i)));
    else if (i < 12) return 8'(sa >> (8 * (11 - i)));
    else if (i == 12) return 8'h88;
    else if (i == 13) return 8'h08;
    else if (i == 14) return 8'h00;
    else if (i == 15) return 8'h01;
    else if (i == 16) return prm[15:8];
    else if (i == 17) return prm[7:0];
    return 8'h00;
  endfunction

  function automatic logic [7:0] rxByte(int i, logic [47:0] dst, logic [15:0] typ,
                                        logic [15:0] opc, logic [15:0] prm);
    if (i < 6)        return 8'(dst >> (8 * (5 - i)));
    else if (i < 12)  return 8'(8'hA0 + i);
    else if (i == 12) return typ[15:8];
    else if (i == 13) return typ[7:0];
    else if (i == 14) return opc[15:8];
    else if (i == 15) return opc[7:0];
    else if (i == 16) return prm[15:8];
    else if (i == 17) return prm[7:0];
    return 8'(i * 7);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expectFrame(input logic [15:0] prm, input string tag);
    int waitN = 0;
    bit bad = 0;
    int badIdx = -1;
    int badAct = 0;
    int badExp = 0;
    while (!(txOutValid && txOutSof) && waitN < 400) begin
      @(negedge clk);
      waitN++;
    end
    if (waitN >= 400) begin
      check(0, {tag, " frame start"}, 0, 1);
      return;
    end
    for (int i = 0; i < 60; i++) begin
      logic [7:0] e;
      if (i > 0) @(negedge clk);
      e = txExp(i, prm, stationAddr);
      if (!bad && (!txOutValid || txOutSof != (i == 0) || txOutEof != (i == 59) || txOutData != e)) begin
        bad = 1; badIdx = i; badAct = int'(txOutData); badExp = int'(e);
      end
    end
    if (bad) $display("FAIL %s: byte %0d actual %0h expected %0h", tag, badIdx, badAct, badExp);
    checks++;
    if (bad) fails++;
  endtask

  task automatic expectNoFrame(input int n, input string tag);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (txOutValid) seen = 1;
    end
    check(!seen, tag, int'(seen), 0);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); quantaTick = 1'b1;
      @(negedge clk); quantaTick = 1'b0;
      if (holdModel > 0) holdModel--;
    end
  endtask

  task automatic sendRx(input logic [47:0] dst, input logic [15:0] typ, input logic [15:0] opc,
                        input logic [15:0] prm, input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rxValid = 1'b1; rxSof = (i == 0); rxEof = (i == len - 1);
      rxData = rxByte(i, dst, typ, opc, prm);
    end
    @(negedge clk);
    rxValid = 1'b0; rxSof = 1'b0; rxEof = 1'b0;
    @(negedge clk);
  endtask

  task automatic goodPause(input logic [15:0] prm, input int len);
    sendRx(DEST_OK, 16'h8808, 16'h0001, prm, len);
    if (rxPauseEn) holdModel = int'(prm);
  endtask

  task automatic checkHold(input string tag);
    check(txHold == (holdModel != 0), tag, int'(txHold), int'(holdModel != 0));
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5eed);
    repeat (4) @(negedge clk);
    check(!txOutValid && !txHold, "R11 reset outputs low", int'(txOutValid | txHold), 0);
    rstN = 1'b1;
    txPauseEn = 1'b1;
    rxPauseEn = 1'b1;
    @(negedge clk);
    check(!txOutValid && !txHold, "R11 idle after reset", int'(txOutValid | txHold), 0);

    // R1 / R2: XOFF on congestion, XON on clearing inside the window
    congested = 1'b1;
    expectFrame(XOFF_Q, "R1 XOFF frame");
    @(negedge clk); congested = 1'b0;
    expectFrame(16'h0000, "R2 XON frame");

    // R3: refresh on expiry, no XON after expiry
    @(negedge clk); congested = 1'b1;
    expectFrame(XOFF_Q, "R3 first XOFF");
    tick(int'(XOFF_Q));
    expectFrame(XOFF_Q, "R3 refreshed XOFF");
    @(negedge clk); txPauseEn = 1'b0;
    tick(int'(XOFF_Q));
    expectNoFrame(10, "R4 no refresh while disabled");
    @(negedge clk); congested = 1'b0;
    @(negedge clk); txPauseEn = 1'b1;
    expectNoFrame(100, "R3 no XON after window closed");

    // R4: disabled generation, then release with a new station address
    stationAddr = {$urandom, $urandom} & 48'hFEFF_FFFF_FFFF;
    @(negedge clk); txPauseEn = 1'b0; congested = 1'b1;
    expectNoFrame(100, "R4 no frame while disabled");
    txPauseEn = 1'b1;
    expectFrame(XOFF_Q, "R4 XOFF after enable");
    @(negedge clk); congested = 1'b0;
    expectFrame(16'h0000, "R4 XON after enable");
    expectNoFrame(20, "R2 single XON");

    // R5 / R6: accept and count down
    goodPause(16'd3, 60);
    checkHold("R5 hold after XOFF");
    tick(2);
    checkHold("R6 hold after two of three ticks");
    tick(1);
    checkHold("R6 hold released on last tick");

    // R7: reload while running
    goodPause(16'd3, 60);
    tick(2);
    goodPause(16'd4, 18);
    tick(3);
    checkHold("R7 reload keeps hold");
    tick(1);
    checkHold("R7 reloaded count expires");

    // R8: XON clears early
    goodPause(16'd10, 60);
    checkHold("R8 hold set");
    goodPause(16'd0, 60);
    checkHold("R8 XON clears hold");

    // R9: damaged frames ignored
    goodPause(16'd5, 60);
    sendRx(DEST_OK, 16'h8808, 16'h0002, 16'd0, 60);
    checkHold("R9 wrong opcode XON ignored");
    sendRx(48'h0180C2000002, 16'h8808, 16'h0001, 16'd0, 60);
    checkHold("R9 wrong destination XON ignored");
    sendRx(DEST_OK, 16'h8809, 16'h0001, 16'd0, 60);
    checkHold("R9 wrong type XON ignored");
    sendRx(DEST_OK, 16'h8808, 16'h0001, 16'd0, 17);
    checkHold("R9 short XON ignored");
    goodPause(16'd0, 60);
    sendRx(48'h0180C2000011, 16'h8808, 16'h0001, 16'd5, 60);
    checkHold("R9 wrong destination XOFF ignored");

    // R10: reaction disabled
    goodPause(16'd7, 60);
    @(negedge clk); rxPauseEn = 1'b0; holdModel = 0;
    @(negedge clk);
    checkHold("R10 hold forced low");
    goodPause(16'd7, 60);
    checkHold("R10 XOFF ignored while disabled");
    rxPauseEn = 1'b1;
    @(negedge clk);
    checkHold("R10 stays low after re-enable");

    // random mix (R5-R9)
    for (int it = 0; it < 40; it++) begin
      int kind;
      kind = $urandom_range(0, 3);
      case (kind)
        0: goodPause(16'($urandom_range(1, 6)), $urandom_range(18, 64));
        1: goodPause(16'd0, $urandom_range(18, 64));
        2: begin
          int defect;
          defect = $urandom_range(0, 3);
          case (defect)
            0: sendRx(DEST_OK ^ 48'h1, 16'h8808, 16'h0001, 16'($urandom_range(0, 6)), 60);
            1: sendRx(DEST_OK, 16'h0800, 16'h0001, 16'($urandom_range(0, 6)), 60);
            2: sendRx(DEST_OK, 16'h8808, 16'h0101, 16'($urandom_range(0, 6)), 60);
            default: sendRx(DEST_OK, 16'h8808, 16'h0001, 16'($urandom_range(0, 6)), $urandom_range(10, 17));
          endcase
        end
        default: @(negedge clk);
      endcase
      tick($urandom_range(0, 5));
      checkHold("R6 random hold model");
    end

    finishRun();
  end
endmodule